// File: doc/BRIEF.md
# Page-Crossing Write Splitter with Write-Permission Gate

The block accepts one memory write request at a time, given as a start address and a byte length, and decides whether the bytes it covers stay within one page or spill into the next one. A request that stays inside its page goes downstream unchanged as a single part. A request that runs past the end of its page becomes two parts. The first covers the bytes up to the page end. The second starts at the base of the next page and carries the remaining bytes. The two parts are always issued in that order.

Before a part is offered downstream, the block presents that part's page number on a lookup port and reads back a single writable flag. The flag comes from a small permission table outside the block and is returned in the same cycle. A part whose page is writable is issued normally. A part whose page is not writable is never issued. Instead, the block raises a page fault that carries the address of the first byte of the refused part, and drops whatever remains of the request. If the refusal falls on the second part, the first part has already completed. A raised fault stays up, and blocks any new request, until it is acknowledged.

The page size and the address width are parameters. The page size must be a power of two.

Top module: `wsplit_top`

## Requirements
- R1: After reset the block is ready for a request (`req_ready`=1) and shows no part (`sub_valid`=0) and no fault (`fault_valid`=0).
- R2: A request whose offset within its page plus its length is at most the page size goes out as one part with the request's own address and length and `sub_last`=1. This includes a request that ends exactly on the last byte of its page.
- R3: A request whose offset within its page plus its length exceeds the page size is split. The first part has the request address, length (page size − offset) and `sub_last`=0. The second part has the next page's base address, the remaining length and `sub_last`=1.
- R4: The second part of a split request is presented only after the first part was accepted (`sub_valid` and `sub_ready` both high at a clock edge). `req_ready` stays low from acceptance of a request until its last part is accepted.
- R5: While a part is pending, `perm_page` shows the page number (address divided by page size) of that part. `sub_valid` is high only in cycles where `perm_writable` is high.
- R6: While `sub_valid` is high and `sub_ready` is low, the part address and length hold their values in the next cycle.
- R7: If the first part's page is not writable, no part is issued. A fault is raised in the next cycle, and `fault_addr` equals the request's start address.
- R8: If the second part's page is not writable, the first part is issued as usual and the second part is never issued. A fault is raised with `fault_addr` equal to the base address of the second page.
- R9: A raised fault keeps `fault_valid` high and `fault_addr` unchanged until `fault_ack` is seen. `req_ready` is low during the fault, and a request offered during the fault is not taken. One cycle after `fault_ack`, the block is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | Block takes a request this cycle |
| req_addr | input | ADDR_W | First byte address of the request |
| req_len | input | LEN_W | Byte count, 1 to MAX_LEN |
| sub_valid | output | 1 | A page-local part is offered downstream |
| sub_ready | input | 1 | Downstream accepts the part |
| sub_addr | output | ADDR_W | First byte address of the part |
| sub_len | output | LEN_W | Byte count of the part |
| sub_last | output | 1 | Part is the final one of its request |
| perm_page | output | ADDR_W−log2(PAGE_BYTES) | Page number being looked up |
| perm_writable | input | 1 | Looked-up page allows writes |
| fault_valid | output | 1 | Page fault pending |
| fault_addr | output | ADDR_W | Address of the first refused byte |
| fault_ack | input | 1 | Clears a pending fault |

## Verification
Two functions can fall into the same request: the first part completes downstream, and the permission check on the second part refuses the next page. The bench provokes this by marking, in its own permission table, only the page that follows a request's start page as read-only, and then offering a request that straddles the boundary. It judges that the first part appears with its own length, that no second part ever appears, and that the fault address is the next page's base rather than the request's start. The reverse case, with the start page refused, is run as well to show that the fault address then moves back to the request address.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

    // Default geometry used by the top level.
    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_PAGE_BYTES = 4096;
    localparam int unsigned DEF_MAX_LEN    = 16;

    // Control sequence of one request.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_FAULT  = 2'd3
    } wsplit_state_e;

    // Bits needed to hold a byte count from 0 to max_len.
    function automatic int unsigned len_bits(input int unsigned max_len);
        return $clog2(max_len + 1);
    endfunction

    // Wider of two widths, plus headroom for a sum and a carry.
    function automatic int unsigned sum_bits(input int unsigned a, input int unsigned b);
        return ((a > b) ? a : b) + 2;
    endfunction

endpackage

// File: rtl/wsplit_calc.sv
module wsplit_calc
    import wsplit_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int unsigned MAX_LEN    = DEF_MAX_LEN,
    localparam int unsigned PAGE_SH   = $clog2(PAGE_BYTES),
    localparam int unsigned LEN_W     = len_bits(MAX_LEN),
    localparam int unsigned PN_W      = ADDR_W - PAGE_SH
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              crosses,
    output logic [LEN_W-1:0]  head_len,
    output logic [ADDR_W-1:0] tail_addr,
    output logic [LEN_W-1:0]  tail_len
);
    localparam int unsigned SUM_W = sum_bits(PAGE_SH, LEN_W);

    logic [PAGE_SH-1:0] offset;
    logic [PN_W-1:0]    page_num;
    logic [PN_W-1:0]    next_page;
    logic [SUM_W-1:0]   end_pos;
    logic [SUM_W-1:0]   room;

    always_comb begin
        offset    = addr[PAGE_SH-1:0];
        page_num  = addr[ADDR_W-1:PAGE_SH];
        next_page = page_num + 1'b1;
        end_pos   = SUM_W'(offset) + SUM_W'(len);
        room      = SUM_W'(PAGE_BYTES) - SUM_W'(offset);
        crosses   = end_pos > SUM_W'(PAGE_BYTES);
        head_len  = crosses ? LEN_W'(room) : len;
        tail_len  = len - head_len;
        tail_addr = {next_page, {PAGE_SH{1'b0}}};
    end

endmodule

// File: rtl/wsplit_ctrl.sv
module wsplit_ctrl
    import wsplit_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int unsigned MAX_LEN    = DEF_MAX_LEN,
    localparam int unsigned PAGE_SH   = $clog2(PAGE_BYTES),
    localparam int unsigned LEN_W     = len_bits(MAX_LEN),
    localparam int unsigned PN_W      = ADDR_W - PAGE_SH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              calc_crosses,
    input  logic [LEN_W-1:0]  calc_head_len,
    input  logic [ADDR_W-1:0] calc_tail_addr,
    input  logic [LEN_W-1:0]  calc_tail_len,
    output logic              sub_valid,
    input  logic              sub_ready,
    output logic [ADDR_W-1:0] sub_addr,
    output logic [LEN_W-1:0]  sub_len,
    output logic              sub_last,
    output logic [PN_W-1:0]   perm_page,
    input  logic              perm_writable,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr,
    input  logic              fault_ack
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } part_t;

    wsplit_state_e     state_q, state_d;
    part_t             head_q, tail_q, cur;
    logic              split_q;
    logic [ADDR_W-1:0] fault_addr_q;
    logic              pending;
    logic              take_req;
    logic              part_done;
    logic              refused;

    always_comb begin
        cur       = (state_q == ST_SECOND) ? tail_q : head_q;
        pending   = (state_q == ST_FIRST) || (state_q == ST_SECOND);
        take_req  = req_valid && (state_q == ST_IDLE);
        part_done = pending && perm_writable && sub_ready;
        refused   = pending && !perm_writable;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_req) state_d = ST_FIRST;
            ST_FIRST: begin
                if (refused)        state_d = ST_FAULT;
                else if (part_done) state_d = split_q ? ST_SECOND : ST_IDLE;
            end
            ST_SECOND: begin
                if (refused)        state_d = ST_FAULT;
                else if (part_done) state_d = ST_IDLE;
            end
            ST_FAULT:  if (fault_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            head_q       <= '0;
            tail_q       <= '0;
            split_q      <= 1'b0;
            fault_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (take_req) begin
                head_q.addr <= req_addr;
                head_q.len  <= calc_head_len;
                tail_q.addr <= calc_tail_addr;
                tail_q.len  <= calc_tail_len;
                split_q     <= calc_crosses;
            end
            if (refused) begin
                fault_addr_q <= cur.addr;
            end
        end
    end

    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        sub_valid   = pending && perm_writable;
        sub_addr    = cur.addr;
        sub_len     = cur.len;
        sub_last    = (state_q == ST_SECOND) || !split_q;
        perm_page   = cur.addr[ADDR_W-1:PAGE_SH];
        fault_valid = (state_q == ST_FAULT);
        fault_addr  = fault_addr_q;
    end

    // R1: nothing is offered in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $fell(rst) |-> req_ready && !sub_valid && !fault_valid);

    // R3: every part offered stays inside one page
    p_part_in_page_r3: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> (32'(sub_addr[PAGE_SH-1:0]) + 32'(sub_len) <= 32'(PAGE_BYTES)));

    // R4: a non-final part is followed by a lookup of the next page
    p_next_page_r4: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && sub_ready && !sub_last) |=>
            (perm_page == $past(perm_page) + 1'b1) && (sub_addr[PAGE_SH-1:0] == '0) && !req_ready);

    // R5: lookup port names the page of the pending part
    p_lookup_page_r5: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> perm_page == sub_addr[ADDR_W-1:PAGE_SH]);

    // R6: an offered part holds while downstream stalls
    p_hold_part_r6: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && !sub_ready) |=> $stable(sub_addr) && $stable(sub_len));

    // R9: a fault stays with a steady address until acknowledged
    p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_valid && !fault_ack) |=> fault_valid && $stable(fault_addr));

    // R9: no request is taken during a fault
    p_fault_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> !req_ready && !sub_valid);

endmodule

// File: rtl/wsplit_top.sv
module wsplit_top
    import wsplit_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int unsigned MAX_LEN    = DEF_MAX_LEN,
    localparam int unsigned PAGE_SH   = $clog2(PAGE_BYTES),
    localparam int unsigned LEN_W     = len_bits(MAX_LEN),
    localparam int unsigned PN_W      = ADDR_W - PAGE_SH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              sub_valid,
    input  logic              sub_ready,
    output logic [ADDR_W-1:0] sub_addr,
    output logic [LEN_W-1:0]  sub_len,
    output logic              sub_last,
    output logic [PN_W-1:0]   perm_page,
    input  logic              perm_writable,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr,
    input  logic              fault_ack
);
    logic              crosses;
    logic [LEN_W-1:0]  head_len;
    logic [ADDR_W-1:0] tail_addr;
    logic [LEN_W-1:0]  tail_len;

    wsplit_calc #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .MAX_LEN    (MAX_LEN)
    ) u_calc (
        .addr      (req_addr),
        .len       (req_len),
        .crosses   (crosses),
        .head_len  (head_len),
        .tail_addr (tail_addr),
        .tail_len  (tail_len)
    );

    wsplit_ctrl #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .MAX_LEN    (MAX_LEN)
    ) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_len        (req_len),
        .calc_crosses   (crosses),
        .calc_head_len  (head_len),
        .calc_tail_addr (tail_addr),
        .calc_tail_len  (tail_len),
        .sub_valid      (sub_valid),
        .sub_ready      (sub_ready),
        .sub_addr       (sub_addr),
        .sub_len        (sub_len),
        .sub_last       (sub_last),
        .perm_page      (perm_page),
        .perm_writable  (perm_writable),
        .fault_valid    (fault_valid),
        .fault_addr     (fault_addr),
        .fault_ack      (fault_ack)
    );

endmodule

// File: tb/wsplit_top_bench.sv
module wsplit_top_bench;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned PAGE_BYTES = 4096;
    localparam int unsigned MAX_LEN    = 16;
    localparam int unsigned LEN_W      = $clog2(MAX_LEN + 1);
    localparam int unsigned PN_W       = ADDR_W - $clog2(PAGE_BYTES);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              sub_valid;
    logic              sub_ready = 1'b1;
    logic [ADDR_W-1:0] sub_addr;
    logic [LEN_W-1:0]  sub_len;
    logic              sub_last;
    logic [PN_W-1:0]   perm_page;
    logic              perm_writable;
    logic              fault_valid;
    logic [ADDR_W-1:0] fault_addr;
    logic              fault_ack = 1'b0;

    logic [PN_W-1:0]   ro_page_a = '1;
    logic [PN_W-1:0]   ro_page_b = '1;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Permission table kept by the bench: two read-only pages.
    always_comb perm_writable = (perm_page != ro_page_a) && (perm_page != ro_page_b);

    wsplit_top #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .MAX_LEN    (MAX_LEN)
    ) u_wsplit_top (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_len       (req_len),
        .sub_valid     (sub_valid),
        .sub_ready     (sub_ready),
        .sub_addr      (sub_addr),
        .sub_len       (sub_len),
        .sub_last      (sub_last),
        .perm_page     (perm_page),
        .perm_writable (perm_writable),
        .fault_valid   (fault_valid),
        .fault_addr    (fault_addr),
        .fault_ack     (fault_ack)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Offer a request; returns at the negedge after it was taken.
    task automatic offer(input logic [ADDR_W-1:0] a, input int unsigned l);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_len   = LEN_W'(l);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_part(input string req, input logic [ADDR_W-1:0] a,
                            input int unsigned l, input bit last);
        chk(req, "sub_valid", 64'(sub_valid), 64'd1);
        chk(req, "sub_addr",  64'(sub_addr),  64'(a));
        chk(req, "sub_len",   64'(sub_len),   64'(l));
        chk(req, "sub_last",  64'(sub_last),  64'(last));
        chk("R5", "perm_page", 64'(perm_page), 64'(a >> 12));
    endtask

    task automatic chk_idle(input string req);
        chk(req, "req_ready",   64'(req_ready),   64'd1);
        chk(req, "sub_valid",   64'(sub_valid),   64'd0);
        chk(req, "fault_valid", 64'(fault_valid), 64'd0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");
    endtask

    task automatic t_single;
        offer(32'h0000_1010, 8);
        chk_part("R2", 32'h0000_1010, 8, 1'b1);
        chk("R4", "req_ready busy", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk_idle("R2");
        // ends exactly on the last byte of the page: no split
        offer(32'h0000_1FF0, 16);
        chk_part("R2", 32'h0000_1FF0, 16, 1'b1);
        @(negedge clk);
        chk_idle("R2");
        // single byte at the very end of a page
        offer(32'h0000_3FFF, 1);
        chk_part("R2", 32'h0000_3FFF, 1, 1'b1);
        @(negedge clk);
        chk_idle("R2");
    endtask

    task automatic t_cross;
        offer(32'h0000_2FFA, 16);
        chk_part("R3", 32'h0000_2FFA, 6, 1'b0);
        @(negedge clk);
        chk_part("R3", 32'h0000_3000, 10, 1'b1);
        chk("R4", "req_ready busy", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk_idle("R4");
        // crossing by one byte
        offer(32'h0000_4FFF, 2);
        chk_part("R3", 32'h0000_4FFF, 1, 1'b0);
        @(negedge clk);
        chk_part("R3", 32'h0000_5000, 1, 1'b1);
        @(negedge clk);
        chk_idle("R3");
    endtask

    task automatic t_backpressure;
        sub_ready = 1'b0;
        offer(32'h0000_8FFC, 8);
        for (int i = 0; i < 3; i++) begin
            chk_part("R6", 32'h0000_8FFC, 4, 1'b0);
            @(negedge clk);
        end
        chk_part("R6", 32'h0000_8FFC, 4, 1'b0);
        sub_ready = 1'b1;
        @(negedge clk);
        chk_part("R4", 32'h0000_9000, 4, 1'b1);
        @(negedge clk);
        chk_idle("R6");
    endtask

    task automatic t_deny_first;
        ro_page_a = PN_W'(5);
        offer(32'h0000_5100, 4);
        chk("R7", "sub_valid refused", 64'(sub_valid), 64'd0);
        chk("R5", "perm_page", 64'(perm_page), 64'h5);
        @(negedge clk);
        chk("R7", "fault_valid", 64'(fault_valid), 64'd1);
        chk("R7", "fault_addr",  64'(fault_addr),  64'h5100);
        // a request offered during the fault must not be taken
        req_valid = 1'b1;
        req_addr  = 32'h0000_A000;
        req_len   = LEN_W'(4);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9", "fault held",  64'(fault_valid), 64'd1);
            chk("R9", "fault_addr",  64'(fault_addr),  64'h5100);
            chk("R9", "req_ready",   64'(req_ready),   64'd0);
            chk("R9", "sub_valid",   64'(sub_valid),   64'd0);
        end
        req_valid = 1'b0;
        fault_ack = 1'b1;
        @(negedge clk);
        fault_ack = 1'b0;
        chk_idle("R9");
        @(negedge clk);
        chk_idle("R9");
        ro_page_a = '1;
    endtask

    task automatic t_deny_second;
        ro_page_b = PN_W'(7);
        offer(32'h0000_6FF8, 12);
        chk_part("R8", 32'h0000_6FF8, 8, 1'b0);
        @(negedge clk);
        chk("R8", "second not issued", 64'(sub_valid), 64'd0);
        chk("R5", "perm_page", 64'(perm_page), 64'h7);
        @(negedge clk);
        chk("R8", "fault_valid", 64'(fault_valid), 64'd1);
        chk("R8", "fault_addr",  64'(fault_addr),  64'h7000);
        chk("R8", "sub_valid",   64'(sub_valid),   64'd0);
        fault_ack = 1'b1;
        @(negedge clk);
        fault_ack = 1'b0;
        chk_idle("R9");
        ro_page_b = '1;
        // normal service resumes
        offer(32'h0000_7FF0, 16);
        chk_part("R2", 32'h0000_7FF0, 16, 1'b1);
        @(negedge clk);
        chk_idle("R2");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_single();
        t_cross();
        t_backpressure();
        t_deny_first();
        t_deny_second();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule